// File: doc/BRIEF.md
# Expansion Bus ROM Window Decoder

This block sits between an 8-bit host bus of the 6502 kind and the firmware ROM of one expansion device. The host turns expansion devices on and off by writing a shared select register in which every device owns one bit. This block keeps the state of its own bit and, while that bit is set, answers host reads in a fixed 2 KB window at 0xD800–0xDFFF with bytes from a synchronous ROM port. It also steers the direction and the active-low output enable of the external bidirectional data transceiver, and lights a select indicator.

All bus inputs (PHI2, R/W, address, data) come through fixed-direction level shifters and are sampled by an internal clock running at 32 times PHI2. PHI2 is synchronised through two stages. Its falling edge is found in the synchronised stream and used as the write strobe. Every output is registered. A bus input that changes at a clock edge shows at the outputs after the second following edge.

The decode compares every address line above the window offset. The device stays off after reset, so the host can checksum the window before it sets up any expansion device.

Top module: `xbus_rom_window`

## Requirements
- R1: While `rst` is high and after it is released, the select latch is clear: `sel_led_o` is 0, `xcvr_oe_n_o` is 1 and `xcvr_dir_o` is 0 until the host selects the device.
- R2: A bus write (R/W low) to the select address, captured at the falling edge of PHI2, sets the latch when data bit 7 is 1 and clears it when data bit 7 is 0.
- R3: Data bits other than bit 7 in a select-register write, and writes to any other address, leave the latch unchanged.
- R4: While selected, a read (R/W high) with PHI2 high and an address in 0xD800–0xDFFF gives `xcvr_oe_n_o` = 0 and `xcvr_dir_o` = 1 (1 means drive toward the host).
- R5: Decoding uses all of A15–A11: reads in 0xC800–0xCFFF, 0xD000–0xD7FF, 0xE000 and up, or any other address outside the window are never driven.
- R6: The select address is a parameter (default 0xD1FF). A read of the select address is never driven.
- R7: Writes are never driven, and nothing is driven while the device is deselected.
- R8: `rom_addr_o` carries address bits A10–A0 of the bus cycle. `data_o` is the ROM port's byte, registered one clock after the ROM returns it.
- R9: `sel_led_o` is high exactly while the select latch is set.
- R10: The transceiver is released (`xcvr_oe_n_o` = 1, `xcvr_dir_o` = 0) by the third internal clock edge after PHI2 is low at an edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal clock at 32 times PHI2 |
| rst | input | 1 | Synchronous active-high reset |
| phi2_i | input | 1 | Host bus phase-2 clock |
| rw_i | input | 1 | Host R/W, 1 = read |
| addr_i | input | 16 | Host address bus |
| data_i | input | 8 | Host data bus, host-to-device side |
| rom_rdata_i | input | 8 | Byte from the synchronous ROM port |
| rom_addr_o | output | 11 | ROM word address |
| data_o | output | 8 | Byte toward the transceiver's device side |
| xcvr_dir_o | output | 1 | Transceiver direction, 1 = toward host |
| xcvr_oe_n_o | output | 1 | Transceiver output enable, active low |
| sel_led_o | output | 1 | Select indicator |

## Verification
On every cycle, the assertions check that the transceiver is enabled only while the device is selected, that an address outside the window or on the select register never leads to driving, and that PHI2 being low forces a release on the next edge. They also check that the latch moves only on a write strobe to its own address. The bench's scenarios show the rest: which data bit matters in a select write, that the C800 mirror stays dark, the ROM bytes returned during a read, and that reset clears an active selection. A cycle-by-cycle model in the bench tracks every output through the two-stage sampling delay.

// File: rtl/xbw_pkg.sv
package xbw_pkg;
  parameter int ADDR_W = 16;
  parameter int DATA_W = 8;
  parameter int SYNC_STAGES = 2;
endpackage

// File: rtl/xbw_bus_sync.sv
module xbw_bus_sync #(
  parameter int ADDR_W = xbw_pkg::ADDR_W,
  parameter int DATA_W = xbw_pkg::DATA_W,
  parameter int STAGES = xbw_pkg::SYNC_STAGES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              phi_i,
  input  logic              rw_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              phi_q,
  output logic              rw_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] data_q,
  output logic              phi_fall
);
  localparam int LAST = STAGES - 1;

  logic              phi_s  [STAGES];
  logic              rw_s   [STAGES];
  logic [ADDR_W-1:0] addr_s [STAGES];
  logic [DATA_W-1:0] data_s [STAGES];
  logic              phi_prev;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) begin
          phi_s[g]  <= 1'b0;
          rw_s[g]   <= 1'b0;
          addr_s[g] <= '0;
          data_s[g] <= '0;
        end else if (g == 0) begin
          phi_s[g]  <= phi_i;
          rw_s[g]   <= rw_i;
          addr_s[g] <= addr_i;
          data_s[g] <= data_i;
        end else begin
          phi_s[g]  <= phi_s[(g == 0) ? 0 : g-1];
          rw_s[g]   <= rw_s[(g == 0) ? 0 : g-1];
          addr_s[g] <= addr_s[(g == 0) ? 0 : g-1];
          data_s[g] <= data_s[(g == 0) ? 0 : g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) phi_prev <= 1'b0;
    else     phi_prev <= phi_s[LAST];
  end

  assign phi_q    = phi_s[LAST];
  assign rw_q     = rw_s[LAST];
  assign addr_q   = addr_s[LAST];
  assign data_q   = data_s[LAST];
  assign phi_fall = phi_prev & ~phi_s[LAST];
endmodule

// File: rtl/xbw_select_latch.sv
module xbw_select_latch #(
  parameter int              ADDR_W   = xbw_pkg::ADDR_W,
  parameter int              DATA_W   = xbw_pkg::DATA_W,
  parameter logic [ADDR_W-1:0] SEL_ADDR = 16'hD1FF,
  parameter int              SEL_BIT  = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strobe_i,
  input  logic              rw_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              sel_o
);
  localparam logic [DATA_W-1:0] OWN_MASK = DATA_W'(1) << SEL_BIT;

  logic hit_wr;
  logic own_val;

  assign hit_wr  = strobe_i && !rw_i && (addr_i == SEL_ADDR);
  assign own_val = |(data_i & OWN_MASK);

  always_ff @(posedge clk) begin
    if (rst)         sel_o <= 1'b0;
    else if (hit_wr) sel_o <= own_val;
  end

  // R2 R3: the latch moves only on a captured write to its own address
  a_r3_sel_moves_on_strobe: assert property (@(posedge clk) disable iff (rst)
    !$stable(sel_o) |-> $past(strobe_i && !rw_i && addr_i == SEL_ADDR));
endmodule

// File: rtl/xbw_window_ctl.sv
module xbw_window_ctl #(
  parameter int                ADDR_W   = xbw_pkg::ADDR_W,
  parameter int                WIN_AW   = 11,
  parameter logic [ADDR_W-1:0] WIN_BASE = 16'hD800,
  parameter logic [ADDR_W-1:0] SEL_ADDR = 16'hD1FF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_i,
  input  logic              phi_i,
  input  logic              rw_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [WIN_AW-1:0] rom_addr_o,
  output logic              xcvr_dir_o,
  output logic              xcvr_oe_n_o
);
  localparam int TAG_W = ADDR_W - WIN_AW;
  localparam logic [TAG_W-1:0] WIN_TAG = WIN_BASE[ADDR_W-1:WIN_AW];

  logic in_win;
  logic drive;

  assign in_win = (addr_i[ADDR_W-1:WIN_AW] == WIN_TAG);
  assign drive  = sel_i && rw_i && phi_i && in_win && (addr_i != SEL_ADDR);

  always_ff @(posedge clk) begin
    if (rst) begin
      xcvr_dir_o  <= 1'b0;
      xcvr_oe_n_o <= 1'b1;
      rom_addr_o  <= '0;
    end else begin
      xcvr_dir_o  <= drive;
      xcvr_oe_n_o <= !drive;
      rom_addr_o  <= addr_i[WIN_AW-1:0];
    end
  end

  // R4 R5: nothing outside the fully decoded window is ever driven
  a_r5_no_alias: assert property (@(posedge clk) disable iff (rst)
    (addr_i[ADDR_W-1:WIN_AW] != WIN_TAG) |=> xcvr_oe_n_o);
  // R6: the select register address is left to other logic
  a_r6_sel_addr_quiet: assert property (@(posedge clk) disable iff (rst)
    (addr_i == SEL_ADDR) |=> xcvr_oe_n_o);
  // R7: writes are never driven
  a_r7_no_write_drive: assert property (@(posedge clk) disable iff (rst)
    !rw_i |=> (xcvr_oe_n_o && !xcvr_dir_o));
  // R10: PHI2 low releases the transceiver on the next edge
  a_r10_release: assert property (@(posedge clk) disable iff (rst)
    !phi_i |=> (xcvr_oe_n_o && !xcvr_dir_o));
endmodule

// File: rtl/xbus_rom_window.sv
module xbus_rom_window #(
  parameter int                ADDR_W   = xbw_pkg::ADDR_W,
  parameter int                DATA_W   = xbw_pkg::DATA_W,
  parameter int                WIN_AW   = 11,
  parameter logic [ADDR_W-1:0] WIN_BASE = 16'hD800,
  parameter logic [ADDR_W-1:0] SEL_ADDR = 16'hD1FF,
  parameter int                SEL_BIT  = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              phi2_i,
  input  logic              rw_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [DATA_W-1:0] rom_rdata_i,
  output logic [WIN_AW-1:0] rom_addr_o,
  output logic [DATA_W-1:0] data_o,
  output logic              xcvr_dir_o,
  output logic              xcvr_oe_n_o,
  output logic              sel_led_o
);
  logic              phi_q;
  logic              rw_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic              phi_fall;
  logic              sel;

  xbw_bus_sync #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STAGES(xbw_pkg::SYNC_STAGES)
  ) u_sync (
    .clk(clk), .rst(rst),
    .phi_i(phi2_i), .rw_i(rw_i), .addr_i(addr_i), .data_i(data_i),
    .phi_q(phi_q), .rw_q(rw_q), .addr_q(addr_q), .data_q(data_q),
    .phi_fall(phi_fall)
  );

  xbw_select_latch #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEL_ADDR(SEL_ADDR), .SEL_BIT(SEL_BIT)
  ) u_sel (
    .clk(clk), .rst(rst),
    .strobe_i(phi_fall), .rw_i(rw_q), .addr_i(addr_q), .data_i(data_q),
    .sel_o(sel)
  );

  xbw_window_ctl #(
    .ADDR_W(ADDR_W), .WIN_AW(WIN_AW), .WIN_BASE(WIN_BASE), .SEL_ADDR(SEL_ADDR)
  ) u_win (
    .clk(clk), .rst(rst),
    .sel_i(sel), .phi_i(phi_q), .rw_i(rw_q), .addr_i(addr_q),
    .rom_addr_o(rom_addr_o), .xcvr_dir_o(xcvr_dir_o), .xcvr_oe_n_o(xcvr_oe_n_o)
  );

  always_ff @(posedge clk) begin
    if (rst) data_o <= '0;
    else     data_o <= rom_rdata_i;
  end

  assign sel_led_o = sel;

  // R7 R9: the transceiver is only enabled while the indicator shows selection
  a_r9_drive_needs_sel: assert property (@(posedge clk) disable iff (rst)
    !xcvr_oe_n_o |-> sel_led_o);
  // R4: direction and enable always agree
  a_r4_dir_agrees: assert property (@(posedge clk) disable iff (rst)
    xcvr_dir_o |-> !xcvr_oe_n_o);
endmodule

// File: tb/xbus_rom_window_tb.sv
module xbus_rom_window_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        phi = 1'b0;
  logic        rw = 1'b1;
  logic [15:0] addr = 16'h0000;
  logic [7:0]  data = 8'h00;
  logic [7:0]  rom_rdata = 8'h00;
  logic [10:0] rom_addr;
  logic [7:0]  data_o;
  logic        dir, oe_n, led;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  xbus_rom_window u_dut (
    .clk(clk), .rst(rst), .phi2_i(phi), .rw_i(rw), .addr_i(addr),
    .data_i(data), .rom_rdata_i(rom_rdata), .rom_addr_o(rom_addr),
    .data_o(data_o), .xcvr_dir_o(dir), .xcvr_oe_n_o(oe_n), .sel_led_o(led)
  );

  function automatic logic [7:0] rom_byte(input logic [10:0] a);
    return a[7:0] ^ {a[10:8], 5'b10110};
  endfunction

  always @(posedge clk) rom_rdata <= rom_byte(rom_addr);

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference: history of sampled inputs, output follows 2 edges later
  logic        hp [0:3];
  logic        hr [0:3];
  logic [15:0] ha [0:3];
  logic [7:0]  hd [0:3];
  bit          sel_m = 1'b0;
  logic        e_oe_n, e_dir, e_led;
  logic [10:0] e_ra;
  logic [7:0]  e_do;
  bit          model_on = 1'b0;

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 4; i++) begin
        hp[i] = 1'b0; hr[i] = 1'b0; ha[i] = '0; hd[i] = '0;
      end
      sel_m = 1'b0;
      e_oe_n = 1'b1; e_dir = 1'b0; e_led = 1'b0; e_ra = '0; e_do = '0;
    end else begin
      logic drv;
      for (int i = 3; i > 0; i--) begin
        hp[i] = hp[i-1]; hr[i] = hr[i-1]; ha[i] = ha[i-1]; hd[i] = hd[i-1];
      end
      hp[0] = phi; hr[0] = rw; ha[0] = addr; hd[0] = data;
      drv = sel_m && hr[2] && hp[2] && (ha[2] >= 16'hD800) && (ha[2] <= 16'hDFFF);
      e_oe_n = !drv;
      e_dir  = drv;
      e_ra   = ha[2][10:0];
      e_do   = rom_rdata;
      if (hp[3] && !hp[2] && !hr[2] && ha[2] == 16'hD1FF) sel_m = hd[2][7];
      e_led = sel_m;
    end
    model_on = 1'b1;
  end

  always @(negedge clk) begin
    if (model_on) begin
      check("R4/R10 oe_n per cycle", {15'b0, oe_n}, {15'b0, e_oe_n});
      check("R4/R10 dir per cycle", {15'b0, dir}, {15'b0, e_dir});
      check("R9 led per cycle", {15'b0, led}, {15'b0, e_led});
      check("R8 rom_addr per cycle", {5'b0, rom_addr}, {5'b0, e_ra});
      check("R8 data per cycle", {8'b0, data_o}, {8'b0, e_do});
    end
  end

  logic       mid_oe, mid_dir, post_oe;
  logic [7:0] mid_data;

  task automatic bus_cycle(input logic [15:0] a, input logic r, input logic [7:0] d);
    @(negedge clk); addr = a; rw = r; data = d; phi = 1'b0;
    repeat (16) @(negedge clk);
    phi = 1'b1;
    repeat (10) @(negedge clk);
    mid_oe = oe_n; mid_dir = dir; mid_data = data_o;
    repeat (6) @(negedge clk);
    phi = 1'b0;
    repeat (3) @(negedge clk);
    post_oe = oe_n;
    repeat (4) @(negedge clk);
    rw = 1'b1;
  endtask

  task automatic read_hit(input logic [15:0] a, input string tag);
    bus_cycle(a, 1'b1, 8'h00);
    check({tag, " oe_n low"}, {15'b0, mid_oe}, 16'h0000);
    check({tag, " dir high"}, {15'b0, mid_dir}, 16'h0001);
    check("R8 rom byte", {8'b0, mid_data}, {8'b0, rom_byte(a[10:0])});
    check("R10 released after PHI2 fall", {15'b0, post_oe}, 16'h0001);
  endtask

  task automatic read_miss(input logic [15:0] a, input string tag);
    bus_cycle(a, 1'b1, 8'h00);
    check(tag, {15'b0, mid_oe}, 16'h0001);
  endtask

  task automatic final_report;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    check("R1 reset oe_n", {15'b0, oe_n}, 16'h0001);
    check("R1 reset dir", {15'b0, dir}, 16'h0000);
    check("R1 reset led", {15'b0, led}, 16'h0000);
    rst = 1'b0;
    repeat (4) @(negedge clk);

    read_miss(16'hD800, "R7 deselected read not driven");
    read_miss(16'hD1FF, "R6 select address read not driven");

    bus_cycle(16'hD1FF, 1'b0, 8'h40);
    check("R3 foreign bit 0x40 ignored", {15'b0, led}, 16'h0000);
    bus_cycle(16'hD1FE, 1'b0, 8'h80);
    check("R3 R6 other address ignored", {15'b0, led}, 16'h0000);
    bus_cycle(16'hD1FF, 1'b0, 8'h80);
    check("R2 select with 0x80", {15'b0, led}, 16'h0001);
    check("R7 write not driven", {15'b0, mid_oe}, 16'h0001);

    read_hit(16'hD800, "R4 D800");
    read_hit(16'hDFFF, "R4 DFFF");
    read_hit(16'hDA55, "R4 DA55");
    read_miss(16'hC800, "R5 C800 mirror");
    read_miss(16'hCFFF, "R5 CFFF mirror");
    read_miss(16'hD7FF, "R5 D7FF below window");
    read_miss(16'hE000, "R5 E000 above window");
    read_miss(16'h5800, "R5 5800 mirror");
    read_miss(16'hD1FF, "R6 select address while selected");

    bus_cycle(16'hD900, 1'b0, 8'h00);
    check("R7 window write not driven", {15'b0, mid_oe}, 16'h0001);
    check("R3 window write leaves latch", {15'b0, led}, 16'h0001);
    bus_cycle(16'hD1FE, 1'b0, 8'h00);
    check("R3 write elsewhere leaves latch", {15'b0, led}, 16'h0001);
    bus_cycle(16'hD1FF, 1'b0, 8'hC0);
    check("R3 0xC0 keeps selected", {15'b0, led}, 16'h0001);
    bus_cycle(16'hD1FF, 1'b0, 8'h7F);
    check("R2 0x7F deselects", {15'b0, led}, 16'h0000);
    read_miss(16'hD800, "R7 read after deselect");

    bus_cycle(16'hD1FF, 1'b0, 8'hFF);
    check("R2 0xFF selects", {15'b0, led}, 16'h0001);
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 reset clears selection", {15'b0, led}, 16'h0000);
    check("R1 reset releases bus", {15'b0, oe_n}, 16'h0001);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    read_miss(16'hD800, "R1 stays off after reset");

    done = 1'b1;
    final_report();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R1 actual=running expected=finished");
      final_report();
      $finish;
    end
  end
endmodule